// File: doc/BRIEF.md
# Sampling Converter Acquisition Controller

This block is the host side of a link to a 12-bit successive-approximation converter that has a start-conversion strobe, a chip select, a serial clock and a serial data return. When a request arrives while the controller is ready, it drives the start strobe low. It waits a fixed number of system-clock cycles for the conversion to finish, then clocks the result in over the serial pins. The 12-bit word is presented on a data port together with a single-cycle valid strobe.

Three mode inputs are sampled with each request. The readout mode selects either plain framing or busy-signalling framing. A padding option selects an extra four serial clocks. A sleep option powers the converter down after the conversion. The power mode and the framing follow from the levels the controller holds on the start strobe and the chip select when the conversion ends. When the converter sleeps, the next request first raises the strobe and waits a power-up interval. After reset the controller runs the start-up reset sequence by itself and only then reports ready. That sequence is one conversion, an aborted four-clock read, and a second conversion.

All waits are counted in system-clock cycles set by parameters. The serial clock is the system clock divided by 2*CLK_DIV.

Top module: `adc_acq_ctrl`

## Requirements
- R1: While rst_ni is low, convst_o and cs_o are high, sclk_o is low, and valid_o and ready_o are low.
- R2: After reset the controller makes exactly two conversions (two convst_o falling edges) and one chip-select frame of exactly 4 sclk_o cycles. It produces no valid_o pulse, and only then raises ready_o.
- R3: Without sleep, convst_o stays low for exactly CONVST_LO_CYC cycles per conversion, and a conversion starts only from a request taken while ready_o is high.
- R4: In plain readout (busy_mode_i=0), cs_o falls exactly CONV_CYC cycles after convst_o falls and the frame holds 12 sclk_o cycles. sclk_o is low whenever cs_o is high.
- R5: In busy readout (busy_mode_i=1), cs_o falls CONVST_LO_CYC cycles after convst_o falls, before the conversion ends, and the frame holds 13 sclk_o cycles.
- R6: sdo_i is sampled on sclk_o rising edges, MSB first, and data_o equals the converter word. In plain readout the first sampled bit is the MSB, driven when cs_o falls. In busy readout the sample on the first rising edge is dropped and the MSB is the sample on the second rising edge.
- R7: With pad16_i=1 the frame holds 4 more sclk_o cycles (16 plain, 17 busy), and the bits taken on them do not reach data_o.
- R8: valid_o is a one-cycle pulse with cs_o high, and data_o holds the result while valid_o is high.
- R9: At least QUIET_CYC cycles pass between the last sclk_o falling edge and the next convst_o falling edge.
- R10: With sleep_i=1, convst_o stays low from the conversion start until the next request. That request raises convst_o for exactly PWRUP_CYC cycles before the next falling edge.
- R11: A request made while ready_o is low is ignored: it starts no conversion and produces no extra valid_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Acquisition request, taken only when ready_o is high |
| busy_mode_i | input | 1 | 1: busy-signalling framing, 0: plain framing |
| pad16_i | input | 1 | Adds four discarded serial clocks to the frame |
| sleep_i | input | 1 | Power the converter down after this conversion |
| ready_o | output | 1 | Idle and able to accept a request |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Conversion result |
| convst_o | output | 1 | Start-conversion strobe to the converter, active low |
| cs_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
The bench sweeps every combination of readout mode, padding and sleep over words that include all-zeros, all-ones and mixed patterns.
- A first-bit slip in busy readout would shift a leading one into the result.
- A wrong clock count would either truncate the word or keep padding bits.
- An off-by-one conversion wait would move the chip-select edge away from the exact CONV_CYC distance.
- A broken wake path would drop the power-up interval after a sleeping sample.

The start-up sequence is checked by its frame length and by the absence of a result. Requests made during a transaction are checked to start nothing.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAKE, ST_CONV, ST_CWAIT, ST_READ, ST_DONE, ST_QUIET
  } acq_state_e;

  typedef enum logic [1:0] {
    BOOT_ABORT, BOOT_FLUSH, BOOT_DONE
  } boot_e;
endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/acq_sclk_gen.sv
module acq_sclk_gen #(
  parameter int DIV = 1,
  parameter int CW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          sclk_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic [CW-1:0] nrise_o,
  output logic [CW-1:0] nfall_o
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          tick;
  logic          sclk_q;
  logic [CW-1:0] nrise_q, nfall_q;

  generate
    if (DIV == 1) begin : g_fast
      assign tick = en_i;
    end else begin : g_div
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (!en_i)         div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick = en_i && (div_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      nrise_q <= '0;
      nfall_q <= '0;
    end else if (!en_i) begin
      sclk_q  <= 1'b0;
      nrise_q <= '0;
      nfall_q <= '0;
    end else if (tick) begin
      sclk_q <= !sclk_q;
      if (sclk_q) nfall_q <= nfall_q + 1'b1;
      else        nrise_q <= nrise_q + 1'b1;
    end
  end

  assign sclk_o  = sclk_q;
  assign rise_o  = tick && !sclk_q;
  assign fall_o  = tick && sclk_q;
  assign nrise_o = nrise_q;
  assign nfall_o = nfall_q;
endmodule

// File: rtl/acq_rx_shift.sv
module acq_rx_shift #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         sdo_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (cap_i) sh_q <= {sh_q[W-2:0], sdo_i};
  end

  assign word_o = sh_q;
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl
  import adc_acq_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int CLK_DIV       = 1,
  parameter int CONV_CYC      = 33,
  parameter int CONVST_LO_CYC = 1,
  parameter int QUIET_CYC     = 3,
  parameter int PWRUP_CYC     = 5000,
  parameter int PAD_CLKS      = 4,
  parameter int ABORT_CLKS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              busy_mode_i,
  input  logic              pad16_i,
  input  logic              sleep_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              convst_o,
  output logic              cs_o,
  output logic              sclk_o,
  input  logic              sdo_i
);
  localparam int TMAX_A    = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int TMAX      = (TMAX_A > QUIET_CYC) ? TMAX_A : QUIET_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int FRAME_MAX = DATA_W + 1 + PAD_CLKS;
  localparam int FCW       = $clog2(FRAME_MAX + 2);

  localparam logic [TW-1:0]  T_LO  = TW'(CONVST_LO_CYC - 1);
  localparam logic [TW-1:0]  T_CW  = TW'(CONV_CYC - CONVST_LO_CYC - 1);
  localparam logic [TW-1:0]  T_Q   = TW'(QUIET_CYC - 1);
  localparam logic [TW-1:0]  T_PU  = TW'(PWRUP_CYC - 1);
  localparam logic [FCW-1:0] F_DAT = FCW'(DATA_W);
  localparam logic [FCW-1:0] F_PAD = FCW'(PAD_CLKS);
  localparam logic [FCW-1:0] F_ABT = FCW'(ABORT_CLKS);

  acq_state_e state_q, state_d;
  boot_e      boot_q;
  logic       busy_q, pad_q, pd_q, asleep_q;
  logic       valid_q;
  logic [DATA_W-1:0] data_q;

  logic [TW-1:0]  tcnt;
  logic           sclk_en, sclk_rise, sclk_fall;
  logic [FCW-1:0] nrise, nfall, idx, first, nclk;
  logic           cap, frame_end;
  logic [DATA_W-1:0] shift_word;
  logic           take_req;

  acq_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .cnt_o  (tcnt)
  );

  assign sclk_en = (state_q == ST_READ);

  acq_sclk_gen #(.DIV(CLK_DIV), .CW(FCW)) u_sclk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (sclk_en),
    .sclk_o  (sclk_o),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall),
    .nrise_o (nrise),
    .nfall_o (nfall)
  );

  // busy framing spends its first rising edge before the MSB is launched
  assign idx   = nrise + 1'b1;
  assign first = busy_q ? FCW'(2) : FCW'(1);
  assign cap   = sclk_rise && (boot_q == BOOT_DONE) &&
                 (idx >= first) && (idx < first + F_DAT);

  acq_rx_shift #(.W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .sdo_i  (sdo_i),
    .word_o (shift_word)
  );

  assign nclk = (boot_q != BOOT_DONE) ? F_ABT :
                F_DAT + FCW'(busy_q) + (pad_q ? F_PAD : '0);
  assign frame_end = sclk_fall && (nfall == nclk - 1'b1);
  assign take_req  = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = asleep_q ? ST_WAKE : ST_CONV;
      ST_WAKE:  if (tcnt == T_PU) state_d = ST_CONV;
      ST_CONV:  if (tcnt == T_LO) state_d = ST_CWAIT;
      ST_CWAIT: if (tcnt == T_CW)
                  state_d = (boot_q == BOOT_FLUSH) ? ST_QUIET : ST_READ;
      ST_READ:  if (frame_end) state_d = ST_DONE;
      ST_DONE:  state_d = ST_QUIET;
      ST_QUIET: if (tcnt == T_Q)
                  state_d = (boot_q == BOOT_DONE) ? ST_IDLE : ST_CONV;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_QUIET;
      boot_q   <= BOOT_ABORT;
      busy_q   <= 1'b0;
      pad_q    <= 1'b0;
      pd_q     <= 1'b0;
      asleep_q <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= 1'b0;
      if (take_req) begin
        busy_q <= busy_mode_i;
        pad_q  <= pad16_i;
        pd_q   <= sleep_i;
      end
      if (state_q == ST_WAKE && state_d == ST_CONV) asleep_q <= 1'b0;
      if (state_q == ST_CWAIT && state_d != ST_CWAIT) begin
        if (pd_q) asleep_q <= 1'b1;
        if (boot_q == BOOT_FLUSH) boot_q <= BOOT_DONE;
      end
      if (state_q == ST_READ && frame_end) begin
        if (boot_q == BOOT_ABORT) begin
          boot_q <= BOOT_FLUSH;
        end else begin
          valid_q <= 1'b1;
          data_q  <= shift_word;
        end
      end
    end
  end

  // strobe level at end of conversion selects the converter power mode
  assign convst_o = !((state_q == ST_CONV) ||
                      (state_q == ST_CWAIT && pd_q) ||
                      (asleep_q && state_q != ST_WAKE));
  // chip-select level at end of conversion selects the framing
  assign cs_o     = !((state_q == ST_READ) ||
                      (state_q == ST_CWAIT && busy_q));
  assign ready_o  = (state_q == ST_IDLE);
  assign valid_o  = valid_q;
  assign data_o   = data_q;
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic valid_o,
  input logic convst_o,
  input logic cs_o,
  input logic sclk_o
);
  a_r4_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> !sclk_o);

  a_r8_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r8_valid_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_o);

  a_r9_start_bus_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(convst_o) |-> (cs_o && !sclk_o));

  a_r11_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_o && !valid_o && !sclk_o));
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_o  (ready_o),
  .valid_o  (valid_o),
  .convst_o (convst_o),
  .cs_o     (cs_o),
  .sclk_o   (sclk_o)
);

// File: tb/adc_acq_ctrl_tb.sv
module adc_acq_ctrl_tb_top;
  localparam int DIV = 2;
  localparam int CONV = 33;
  localparam int LO = 1;
  localparam int QUIET = 3;
  localparam int PWRUP = 200;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, busy_mode_i = 1'b0, pad16_i = 1'b0, sleep_i = 1'b0;
  logic sdo_i = 1'b0;
  logic ready_o, valid_o, convst_o, cs_o, sclk_o;
  logic [11:0] data_o;

  always #10 clk = ~clk;

  adc_acq_ctrl #(
    .DATA_W(12), .CLK_DIV(DIV), .CONV_CYC(CONV), .CONVST_LO_CYC(LO),
    .QUIET_CYC(QUIET), .PWRUP_CYC(PWRUP), .PAD_CLKS(4), .ABORT_CLKS(4)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .busy_mode_i(busy_mode_i),
    .pad16_i(pad16_i), .sleep_i(sleep_i), .ready_o(ready_o), .valid_o(valid_o),
    .data_o(data_o), .convst_o(convst_o), .cs_o(cs_o), .sclk_o(sclk_o),
    .sdo_i(sdo_i)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model and monitor state
  logic [11:0] m_word = 12'h000;
  bit m_busy = 0;
  int m_idx = 0;
  logic p_convst = 1, p_cs = 1, p_sclk = 0, p_valid = 0;
  int t_cf = 0, t_cr = 0, t_sf = 0, lo_w = 0, cs_delta = 0;
  bit have_sf = 0;
  int rises = 0, fr_rises = 0, n_cf = 0, n_frames = 0, n_valid = 0;
  int vcount = 0, last_vw = 0;
  logic [11:0] last_data = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (p_convst && !convst_o) begin
        n_cf++;
        if (have_sf) chk(cyc - t_sf >= QUIET, "R9 quiet gap", cyc - t_sf, QUIET);
        if (lo_w > CONV) chk(cyc - t_cr == PWRUP, "R10 wake time", cyc - t_cr, PWRUP);
        lo_w = 0;
        t_cf = cyc;
      end
      if (!p_convst && convst_o) begin
        t_cr = cyc;
        lo_w = cyc - t_cf;
      end
      if (p_cs && !cs_o) begin
        cs_delta = cyc - t_cf;
        rises = 0;
        m_idx = 0;
        sdo_i = m_busy ? 1'b1 : m_word[11];
      end
      if (!p_cs && cs_o) begin
        fr_rises = rises;
        n_frames++;
      end
      if (!p_sclk && sclk_o) rises++;
      if (p_sclk && !sclk_o) begin
        t_sf = cyc;
        have_sf = 1;
        m_idx++;
        if (m_busy) sdo_i = (m_idx <= 12) ? m_word[12-m_idx] : 1'b1;
        else        sdo_i = (m_idx < 12) ? m_word[11-m_idx] : 1'b1;
      end
      if (valid_o) begin
        vcount++;
        if (!p_valid) begin
          n_valid++;
          last_data = data_o;
        end
      end else if (p_valid) begin
        last_vw = vcount;
        vcount = 0;
      end
    end
    p_convst = convst_o; p_cs = cs_o; p_sclk = sclk_o; p_valid = valid_o;
  end

  always @(negedge clk) begin
    if (cyc == WD_LIMIT && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic run_txn(input bit b, input bit p16, input bit pd, input logic [11:0] w);
    int nv0, exp_r;
    while (!ready_o) @(negedge clk);
    m_word = w; m_busy = b;
    busy_mode_i = b; pad16_i = p16; sleep_i = pd;
    nv0 = n_valid;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    while (n_valid == nv0) @(negedge clk);
    while (!ready_o) @(negedge clk);
    @(negedge clk);
    exp_r = 12 + int'(b) + (p16 ? 4 : 0);
    chk(last_data == w, "R6 data word", int'(last_data), int'(w));
    chk(fr_rises == exp_r, p16 ? "R7 padded clock count" :
        (b ? "R5 busy clock count" : "R4 plain clock count"), fr_rises, exp_r);
    if (b) chk(cs_delta == LO, "R5 cs before conversion end", cs_delta, LO);
    else   chk(cs_delta == CONV, "R4 cs after conversion", cs_delta, CONV);
    if (pd) chk(convst_o == 1'b0, "R10 strobe held low", int'(convst_o), 0);
    else    chk(lo_w == LO, "R3 strobe pulse width", lo_w, LO);
    chk(last_vw == 1, "R8 valid width", last_vw, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(convst_o == 1 && cs_o == 1, "R1 reset strobes high", int'({convst_o, cs_o}), 3);
    chk(sclk_o == 0, "R1 reset sclk low", int'(sclk_o), 0);
    chk(valid_o == 0 && ready_o == 0, "R1 reset valid/ready low", int'({valid_o, ready_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o == 0, "R2 not ready during boot", int'(ready_o), 0);
    while (!ready_o) @(negedge clk);
    chk(n_cf == 2, "R2 boot conversions", n_cf, 2);
    chk(n_frames == 1, "R2 boot frames", n_frames, 1);
    chk(fr_rises == 4, "R2 aborted frame clocks", fr_rises, 4);
    chk(n_valid == 0, "R2 no boot result", n_valid, 0);

    for (int b = 0; b < 2; b++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 4; k++) begin
            logic [11:0] w;
            if (k == 0) w = 12'h000;
            else if (k == 1) w = 12'hFFF;
            else w = 12'(k * 12'h5A7 + b * 12'h111 + p * 12'h0F3 + s * 12'h3C1);
            run_txn(b[0], p[0], s[0], w);
          end

    // R11: request pulsed mid-transaction must not start another
    begin
      int cf0, nv0;
      while (!ready_o) @(negedge clk);
      cf0 = n_cf; nv0 = n_valid;
      m_word = 12'h6C3; m_busy = 0;
      busy_mode_i = 0; pad16_i = 0; sleep_i = 0;
      req_i = 1'b1; @(negedge clk); req_i = 1'b0;
      repeat (10) @(negedge clk);
      req_i = 1'b1; @(negedge clk); req_i = 1'b0;
      repeat (300) @(negedge clk);
      chk(n_cf == cf0 + 1, "R11 extra request ignored", n_cf - cf0, 1);
      chk(n_valid == nv0 + 1, "R11 single result", n_valid - nv0, 1);
      chk(last_data == 12'h6C3, "R6 data after ignored request", int'(last_data), 'h6C3);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule